// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block sits on the host side of an asynchronous 8-bit NAND flash part and turns one read request into the whole bus conversation needed to fetch bytes from a page. The requester gives a column, a row (page) address and a byte count, then pulses a start strobe. The sequencer sends the read-setup command, five address bytes and the read-confirm command. It then waits out the array access on the ready/busy line and clocks the requested number of bytes out of the device's page register with read-enable pulses. Each byte goes back to the requester with a valid flag, and the final byte also carries a last flag.

All strobe timing is counted in system clocks, so the same RTL serves any clock rate once the pulse widths are set. A busy line that never returns to ready ends the operation with an error instead of hanging. The requester sees a plain start/busy/done handshake with an error bit that is valid when done is high.

The parameters WE_LO, WE_HI, RE_LO and RE_HI must each be at least 1, and WB_CYC must be smaller than TIMEOUT_CYC.

Top module: `nand_rd_seq`

## Requirements
- R1: Out of reset, nf_ce_n, nf_we_n and nf_re_n are high, nf_cle, nf_ale and nf_dq_oe are low, and req_busy, req_done and rd_valid are low.
- R2: An accepted request produces exactly seven bus writes. The first is command 0x00 with nf_cle high. Five address bytes follow with nf_ale high. The last is command 0x30 with nf_cle high. In each write nf_we_n is low for WE_LO clocks and then high for WE_HI clocks, and nf_dq_out with nf_dq_oe high stays unchanged from the fall of nf_we_n through its rise.
- R3: The address bytes go out in this order: col[7:0], then {5'b0, col[10:8]}, then row[7:0], then row[15:8], then {5'b0, row[18:16]}. This places column bit 0, column bit 8 and row bits 0, 8 and 16 (device address bits 0, 8, 11, 19 and 27) at bit 0 of the five cycles.
- R4: nf_cle and nf_ale are never high together, and nf_dq_oe is high only while one of them is high.
- R5: Once the confirm write ends, nf_rb_n is ignored for WB_CYC clocks. After that the first read pulse starts on the clock after nf_rb_n is sampled high. With the line already high, the first nf_re_n fall comes WE_HI + WB_CYC + 1 clocks after the confirm's nf_we_n rise.
- R6: Exactly req_len bytes are read. Each nf_re_n pulse is low for RE_LO clocks and high for RE_HI clocks. The byte on nf_dq_in is taken on the last low clock and shown on rd_data with rd_valid for one clock. rd_last is high only with the final byte.
- R7: If nf_rb_n is not seen ready within TIMEOUT_CYC clocks of the wait starting, no read pulse is issued and the operation ends with req_err high.
- R8: req_busy is high from the clock after an accepted start through the done clock. req_done is a one-clock pulse. req_err is low on done for an operation that completed normally, including one that follows a failed operation.
- R9: A req_start while req_busy is high has no effect on the operation in progress and produces no second command sequence. A start in idle is accepted.
- R10: A request with req_len of 0 sends the full command sequence, waits for ready, issues no read pulse and completes without error.
- R11: nf_we_n and nf_re_n are never low together, and nf_ce_n is low whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start strobe, taken only when idle |
| req_row | input | 19 | Page (row) address |
| req_col | input | 11 | Starting column within the page |
| req_len | input | LEN_W | Number of bytes to read |
| req_busy | output | 1 | Operation in progress |
| req_done | output | 1 | One-clock completion pulse |
| req_err | output | 1 | Ready timeout occurred (valid with req_done) |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | rd_data holds a new byte |
| rd_last | output | 1 | Current byte is the final one |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus value driven toward the device |
| nf_dq_oe | output | 1 | Output enable for nf_dq_out |
| nf_dq_in | input | 8 | Bus value returned by the device |
| nf_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The hardest condition to reach from the ports is a ready/busy line that never releases, since a normal device always returns to ready. The bench's device model has a per-request busy length. Setting it far past the timeout pushes the controller into its error exit, and the next request checks that the error clears. A second hard case is a start strobe that arrives in the middle of an operation. The bench raises one such strobe with a different address while the previous request is under way, then checks that the device model logged only one command sequence and received the original address.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

  localparam int COL_BITS   = 11;
  localparam int ROW_BITS   = 19;
  localparam int NUM_WR     = 7;
  localparam logic [7:0] CMD_SETUP   = 8'h00;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } nrs_state_e;

  // Bus byte for write slot idx: command, five address cycles, confirm.
  function automatic logic [7:0] wr_byte(input logic [2:0] idx,
                                         input logic [COL_BITS-1:0] col,
                                         input logic [ROW_BITS-1:0] row);
    logic [7:0] b;
    case (idx)
      3'd0:    b = CMD_SETUP;
      3'd1:    b = col[7:0];
      3'd2:    b = {5'b0, col[10:8]};
      3'd3:    b = row[7:0];
      3'd4:    b = row[15:8];
      3'd5:    b = {5'b0, row[18:16]};
      default: b = CMD_CONFIRM;
    endcase
    return b;
  endfunction

  function automatic logic is_cmd_slot(input logic [2:0] idx);
    return (idx == 3'd0) || (idx == 3'(NUM_WR - 1));
  endfunction

endpackage

// File: rtl/nrs_strobe.sv
module nrs_strobe #(
  parameter int LO = 2,
  parameter int HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic strobe_n,
  output logic sample,
  output logic slot_end
);
  localparam int SLOT = LO + HI;
  localparam int CW   = $clog2(SLOT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (!en)                  cnt <= '0;
    else if (cnt == CW'(SLOT - 1)) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign strobe_n = !(en && (cnt < CW'(LO)));
  assign sample   = en && (cnt == CW'(LO - 1));
  assign slot_end = en && (cnt == CW'(SLOT - 1));

endmodule

// File: rtl/nrs_wait_timer.sv
module nrs_wait_timer #(
  parameter int WB_CYC      = 4,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rb_n,
  output logic ready_go,
  output logic timed_out
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (!en) cnt <= '0;
    else         cnt <= cnt + 1'b1;
  end

  assign ready_go  = en && (cnt >= CW'(WB_CYC)) && rb_n;
  assign timed_out = en && !ready_go && (cnt == CW'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
  import nrs_pkg::*;
#(
  parameter int WE_LO       = 2,
  parameter int WE_HI       = 2,
  parameter int RE_LO       = 2,
  parameter int RE_HI       = 2,
  parameter int WB_CYC      = 4,
  parameter int TIMEOUT_CYC = 100000,
  parameter int LEN_W       = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_start,
  input  logic [18:0]         req_row,
  input  logic [10:0]         req_col,
  input  logic [LEN_W-1:0]    req_len,
  output logic                req_busy,
  output logic                req_done,
  output logic                req_err,
  output logic [7:0]          rd_data,
  output logic                rd_valid,
  output logic                rd_last,
  output logic                nf_ce_n,
  output logic                nf_cle,
  output logic                nf_ale,
  output logic                nf_we_n,
  output logic                nf_re_n,
  output logic [7:0]          nf_dq_out,
  output logic                nf_dq_oe,
  input  logic [7:0]          nf_dq_in,
  input  logic                nf_rb_n
);
  localparam logic [2:0] LAST_WR = 3'(NUM_WR - 1);

  nrs_state_e            state;
  logic [2:0]            wr_idx;
  logic [COL_BITS-1:0]   col_q;
  logic [ROW_BITS-1:0]   row_q;
  logic [LEN_W-1:0]      remain;
  logic                  err_q;

  // Named internal events
  logic in_wr, in_wait, in_read;
  logic wr_sample, wr_slot_end, rd_sample, rd_slot_end;
  logic ready_go, timed_out, accept;

  assign in_wr   = (state == ST_WR);
  assign in_wait = (state == ST_WAIT);
  assign in_read = (state == ST_READ);
  assign accept  = (state == ST_IDLE) && req_start;

  nrs_strobe #(.LO(WE_LO), .HI(WE_HI)) u_we_strobe (
    .clk(clk), .rst_n(rst_n), .en(in_wr),
    .strobe_n(nf_we_n), .sample(wr_sample), .slot_end(wr_slot_end)
  );

  nrs_strobe #(.LO(RE_LO), .HI(RE_HI)) u_re_strobe (
    .clk(clk), .rst_n(rst_n), .en(in_read),
    .strobe_n(nf_re_n), .sample(rd_sample), .slot_end(rd_slot_end)
  );

  nrs_wait_timer #(.WB_CYC(WB_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(in_wait), .rb_n(nf_rb_n),
    .ready_go(ready_go), .timed_out(timed_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wr_idx   <= '0;
      col_q    <= '0;
      row_q    <= '0;
      remain   <= '0;
      err_q    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      case (state)
        ST_IDLE: if (req_start) begin
          col_q  <= req_col;
          row_q  <= req_row;
          remain <= req_len;
          err_q  <= 1'b0;
          wr_idx <= '0;
          state  <= ST_WR;
        end
        ST_WR: if (wr_slot_end) begin
          if (wr_idx == LAST_WR) state <= ST_WAIT;
          else                   wr_idx <= wr_idx + 1'b1;
        end
        ST_WAIT: begin
          if (ready_go) begin
            state <= (remain == '0) ? ST_DONE : ST_READ;
          end else if (timed_out) begin
            err_q <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_READ: begin
          if (rd_sample) begin
            rd_data  <= nf_dq_in;
            rd_valid <= 1'b1;
            rd_last  <= (remain == LEN_W'(1));
            remain   <= remain - 1'b1;
          end
          if (rd_slot_end && (remain == '0)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_busy  = (state != ST_IDLE);
  assign req_done  = (state == ST_DONE);
  assign req_err   = err_q;
  assign nf_ce_n   = !(in_wr || in_wait || in_read);
  assign nf_cle    = in_wr && is_cmd_slot(wr_idx);
  assign nf_ale    = in_wr && !is_cmd_slot(wr_idx);
  assign nf_dq_oe  = in_wr;
  assign nf_dq_out = in_wr ? wr_byte(wr_idx, col_q, row_q) : 8'h00;

  // ---------------- assertions ----------------
  a_r4_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  a_r4_oe_with_latch: assert property (@(posedge clk) disable iff (!rst_n)
    nf_dq_oe |-> (nf_cle || nf_ale));

  a_r2_bus_stable_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> ($stable(nf_dq_out) && nf_dq_oe));

  a_r2_sample_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sample |-> (!nf_we_n && nf_dq_oe));

  a_r11_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  a_r11_ce_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  a_r5_read_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read && $past(state) == ST_WAIT) |-> $past(nf_rb_n));

  a_r7_err_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(state) == ST_WAIT));

  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && !req_done) |=> ($stable(row_q) && $stable(col_q)));

endmodule

// File: tb/nand_rd_seq_bench.sv
module nand_rd_seq_bench;
  localparam int WE_LO = 3, WE_HI = 2, RE_LO = 2, RE_HI = 2;
  localparam int WB_CYC = 5, TIMEOUT_CYC = 300, LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0;
  logic [18:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_busy, req_done, req_err;
  logic [7:0] rd_data;
  logic rd_valid, rd_last;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq_out;
  logic [7:0] nf_dq_in = 8'h00;
  logic nf_rb_n = 1'b1;

  always #10 clk = ~clk;

  nand_rd_seq #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
                .WB_CYC(WB_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .LEN_W(LEN_W))
  u_nand_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_row(req_row),
    .req_col(req_col), .req_len(req_len), .req_busy(req_busy),
    .req_done(req_done), .req_err(req_err), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_last(rd_last), .nf_ce_n(nf_ce_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
    .nf_rb_n(nf_rb_n)
  );

  int checks = 0, fails = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'((r * 13 + c * 7 + 1) & 255);
  endfunction

  // ---------------- device model and monitors ----------------
  logic [9:0] wlog[$];            // {cle, ale, dq}
  int  dev_busy_cyc = 0, busy_left = 0;
  int  confirm_cyc = -1, ready_cyc = -1, first_re_cyc = -1;
  int  dev_idx = 0, got = 0, done_cnt = 0;
  int  exp_row = 0, exp_col = 0, exp_len = 0;
  int  dec_row = 0, dec_col = 0;
  int  bad_r4 = 0, bad_r11 = 0;
  int  we_run = 0, re_lo_run = 0, re_hi_run = 0;
  bit  re_hi_valid = 0;
  logic we_prev = 1'b1, re_prev = 1'b1;
  logic [7:0] we_dq0 = 8'h00;

  always @(negedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (rst_n) begin
      if (nf_cle && nf_ale) bad_r4++;
      if (nf_dq_oe && !(nf_cle || nf_ale)) bad_r4++;
      if (!nf_we_n && !nf_re_n) bad_r11++;
      if ((!nf_we_n || !nf_re_n) && nf_ce_n) bad_r11++;
      if (req_done) done_cnt++;

      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) begin nf_rb_n = 1'b1; ready_cyc = cyc; end
      end

      // write strobe
      if (!nf_we_n) begin
        if (we_prev) begin we_run = 1; we_dq0 = nf_dq_out; end
        else we_run++;
      end else if (!we_prev) begin
        check(we_run == WE_LO, "R2", "WE low width", we_run, WE_LO);
        check(nf_dq_oe && nf_dq_out == we_dq0, "R2", "bus held over WE",
              int'(nf_dq_out), int'(we_dq0));
        wlog.push_back({nf_cle, nf_ale, nf_dq_out});
        if (nf_cle && nf_dq_out == 8'h30) begin
          confirm_cyc = cyc;
          if (wlog.size() == 7) begin
            dec_col = {wlog[2][2:0], wlog[1][7:0]};
            dec_row = {wlog[5][2:0], wlog[4][7:0], wlog[3][7:0]};
          end
          if (dev_busy_cyc > 0) begin nf_rb_n = 1'b0; busy_left = dev_busy_cyc; end
        end
      end

      // read strobe
      if (!nf_re_n && re_prev) begin
        if (re_hi_valid) check(re_hi_run == RE_HI, "R6", "RE high width", re_hi_run, RE_HI);
        if (first_re_cyc < 0) first_re_cyc = cyc;
        check(nf_rb_n == 1'b1, "R5", "RE while busy", int'(nf_rb_n), 1);
        nf_dq_in = pat(dec_row, dec_col + dev_idx);
        dev_idx++;
        re_lo_run = 1;
      end else if (!nf_re_n) begin
        re_lo_run++;
      end else if (!re_prev) begin
        check(re_lo_run == RE_LO, "R6", "RE low width", re_lo_run, RE_LO);
        re_hi_run = 1; re_hi_valid = 1;
      end else begin
        re_hi_run++;
      end

      // requester side
      if (rd_valid) begin
        check(rd_data == pat(exp_row, exp_col + got), "R6", "read byte",
              int'(rd_data), int'(pat(exp_row, exp_col + got)));
        check(rd_last == (got == exp_len - 1), "R6", "last flag",
              int'(rd_last), int'(got == exp_len - 1));
        got++;
      end
    end
    we_prev = nf_we_n;
    re_prev = nf_re_n;
  end

  // ---------------- one request ----------------
  task automatic run_req(input int row, input int col, input int len,
                         input int busy, input bit exp_err, input bit spurious);
    bit seen = 0;
    @(negedge clk);
    wlog.delete();
    dev_idx = 0; got = 0; done_cnt = 0; re_hi_valid = 0;
    dev_busy_cyc = busy; busy_left = 0; nf_rb_n = 1'b1;
    confirm_cyc = -1; ready_cyc = -1; first_re_cyc = -1;
    bad_r4 = 0; bad_r11 = 0;
    exp_row = row; exp_col = col; exp_len = len;
    req_row = 19'(row); req_col = 11'(col); req_len = LEN_W'(len);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    check(req_busy == 1'b1, "R8", "busy after start", int'(req_busy), 1);
    for (int i = 0; i < 5000 && !seen; i++) begin
      if (req_done) seen = 1;
      else begin
        if (spurious && i == 10) begin
          req_row = 19'(row ^ 19'h155); req_col = 11'(col ^ 11'h2A);
          req_len = LEN_W'(len + 3); req_start = 1'b1;
        end else req_start = 1'b0;
        @(negedge clk);
      end
    end
    req_start = 1'b0;
    check(seen, "R8", "done seen", int'(seen), 1);
    if (exp_err) check(req_err == 1'b1, "R7", "error on timeout", int'(req_err), 1);
    else         check(req_err == 1'b0, "R8", "error clear", int'(req_err), 0);
    @(negedge clk);
    check(!req_done && !req_busy, "R8", "done one clock",
          int'({req_done, req_busy}), 0);
    check(done_cnt == 1, spurious ? "R9" : "R8", "done pulses", done_cnt, 1);
    check(wlog.size() == 7, spurious ? "R9" : "R2", "write count", wlog.size(), 7);
    if (wlog.size() == 7) begin
      check(wlog[0] == {2'b10, 8'h00}, "R2", "setup command", int'(wlog[0]), 10'h200);
      check(wlog[6] == {2'b10, 8'h30}, "R2", "confirm command", int'(wlog[6]), 10'h230);
      for (int k = 1; k <= 5; k++)
        check(wlog[k][9:8] == 2'b01, "R2", "address latch", int'(wlog[k][9:8]), 1);
      check(wlog[2][7:3] == 0 && wlog[5][7:3] == 0, "R3", "address pad bits",
            int'({wlog[2][7:3], wlog[5][7:3]}), 0);
      check(dec_col == col, "R3", "column decode", dec_col, col);
      check(dec_row == row, "R3", "row decode", dec_row, row);
    end
    check(got == (exp_err ? 0 : len), len == 0 ? "R10" : "R6", "byte count",
          got, exp_err ? 0 : len);
    check(bad_r4 == 0, "R4", "latch/oe overlap", bad_r4, 0);
    check(bad_r11 == 0, "R11", "strobe/ce conflict", bad_r11, 0);
    if (exp_err || len == 0)
      check(first_re_cyc == -1, exp_err ? "R7" : "R10", "no RE pulse", first_re_cyc, -1);
    else if (busy == 0)
      check(first_re_cyc - confirm_cyc == WE_HI + WB_CYC + 1, "R5", "ready delay",
            first_re_cyc - confirm_cyc, WE_HI + WB_CYC + 1);
    else
      check(first_re_cyc - ready_cyc == 1, "R5", "ready to RE",
            first_re_cyc - ready_cyc, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset values
    check(nf_ce_n && nf_we_n && nf_re_n, "R1", "strobes idle in reset",
          int'({nf_ce_n, nf_we_n, nf_re_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(!nf_cle && !nf_ale && !nf_dq_oe, "R1", "latches idle",
          int'({nf_cle, nf_ale, nf_dq_oe}), 0);
    check(!req_busy && !req_done && !rd_valid, "R1", "handshake idle",
          int'({req_busy, req_done, rd_valid}), 0);

    run_req(19'h5A3C1, 11'h123, 16, 30, 1'b0, 1'b0);  // R2 R3 R6
    run_req(19'h7FFFF, 11'h7FF, 3, 25, 1'b0, 1'b0);   // R3 boundary
    run_req(0, 0, 1, 0, 1'b0, 1'b0);                  // R5 no busy
    run_req(19'h01234, 11'h040, 0, 25, 1'b0, 1'b0);   // R10
    run_req(19'h2AAAA, 11'h555, 8, 1000, 1'b1, 1'b0); // R7
    run_req(19'h10F0F, 11'h00A, 5, 22, 1'b0, 1'b0);   // R8 err clears
    run_req(19'h33333, 11'h321, 20, 40, 1'b0, 1'b1);  // R9 spurious start
    run_req(19'h00100, 11'h001, 2, 21, 1'b0, 1'b0);   // R9 accepted in idle

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule